// File: doc/BRIEF.md
# Three-Wire Serial Shifter

This block moves one byte at a time over three lines: a shift clock, a serial input and a serial output. The same shift register serves both roles. As master it makes the shift clock itself from the system clock through a selectable divider. As slave it takes the shift clock from outside, brings it into the system clock domain and acts on its edges. Software loads a byte with a one-cycle write strobe. In master mode that write starts the transfer at once. In slave mode it arms the shifter, which then waits for the remote clock.

While a byte is in flight the `ready` output is high. After the eighth bit the received byte appears on `rx_data`, and `done_irq` pulses for one cycle as the interrupt request. Two format controls are available. One picks the bit order, most or least significant bit first. The other picks the sampling edge. The shift clock rests at a level that makes its first edge away from rest the sampling edge. The edge that brings it back to rest is the one on which the next output bit is driven.

Top module: `tri_wire_shifter`

## Requirements
- R1: After reset `ready` is 0, `done_irq` is 0 and `rx_data` is 0. Once reset has been released, `sclk_out` rests at the level given by `cfg_sample_fall`.
- R2: A `tx_wr` pulse while `ready` is 0 raises `ready` on the next cycle. In master mode `sclk_out` still sits at its rest level in that cycle: 0 when `cfg_sample_fall`=0 and 1 when it is 1.
- R3: With `cfg_lsb_first`=0 the byte leaves on `sdo` starting with bit 7, one bit for each sampling edge.
- R4: With `cfg_lsb_first`=1 the byte leaves on `sdo` starting with bit 0.
- R5: The bit sampled from `sdi` at each sampling edge (the edge away from rest) is collected. The first bit received lands in bit 7 when `cfg_lsb_first`=0 and in bit 0 when it is 1. The loaded byte leaves on `sdo`, and the collected byte is presented on `rx_data` at the end of the transfer.
- R6: In master mode each half-period of `sclk_out` lasts 2^`cfg_div_sel` system cycles. `ready` therefore stays high for exactly 16·2^`cfg_div_sel` cycles. Setting 0 gives the fastest shift clock.
- R7: `done_irq` is a one-cycle pulse in the first cycle that `ready` is low again. `rx_data` changes only in that cycle.
- R8: In slave mode (`cfg_master`=0) the transfer is clocked by `sclk_in` after synchronization. Eight sampling edges followed by eight return edges complete a byte.
- R9: In slave mode, `sclk_in` edges while the shifter is not armed have no effect. `ready` and `done_irq` stay 0, and the next armed transfer is unaffected.
- R10: A `tx_wr` pulse while `ready` is 1 is ignored. The byte in flight, its duration and its result are unchanged.
- R11: In slave mode `sclk_out` stays at its rest level throughout a transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_master | input | 1 | 1: generate shift clock; 0: follow `sclk_in` |
| cfg_lsb_first | input | 1 | 1: bit 0 first; 0: bit 7 first |
| cfg_sample_fall | input | 1 | Rest level of shift clock; 1 samples on falling edge |
| cfg_div_sel | input | 2 | Master half-period = 2^value system cycles |
| tx_wr | input | 1 | One-cycle write strobe for `tx_data` |
| tx_data | input | 8 | Byte to transmit |
| rx_data | output | 8 | Last byte received |
| ready | output | 1 | High while a transfer is in progress |
| done_irq | output | 1 | One-cycle interrupt request after a byte |
| sclk_out | output | 1 | Shift clock driven in master mode |
| sclk_in | input | 1 | External shift clock for slave mode |
| sdi | input | 1 | Serial data in |
| sdo | output | 1 | Serial data out |

## Verification
Master transfers loop `sdo` back to `sdi` and cover every divider setting, both bit orders and both sampling edges. The order of bits seen on `sdo` separates MSB-first from LSB-first, where a loopback alone cannot. The length of `ready` separates the divider settings. Slave transfers send a byte that differs from the one loaded, so a swap of the receive and transmit paths shows up. One slave run is preceded by stray clock edges while unarmed, and one master run carries a second write partway through. Both must leave the result untouched.

// File: rtl/ssh_pkg.sv
package ssh_pkg;
  localparam int WORD_W      = 8;
  localparam int DIV_STAGES  = 4;
  localparam int SYNC_STAGES = 2;

  typedef struct packed {
    logic smp;
    logic drv;
  } ssh_stb_t;
endpackage

// File: rtl/ssh_mclk_gen.sv
module ssh_mclk_gen
  import ssh_pkg::*;
#(
  parameter int STAGES = DIV_STAGES
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      en,
  input  logic                      idle_lvl,
  input  logic [$clog2(STAGES)-1:0] div_sel,
  output logic                      sclk,
  output ssh_stb_t                  stb
);
  localparam int CNT_W = (STAGES > 1) ? STAGES - 1 : 1;

  logic [CNT_W-1:0] div_q, div_n, lim;
  logic             sclk_q, sclk_n, tog;

  always_comb begin
    lim    = CNT_W'((1 << div_sel) - 1);
    div_n  = div_q;
    sclk_n = sclk_q;
    tog    = 1'b0;
    if (!en) begin
      div_n  = '0;
      sclk_n = idle_lvl;
    end else if (div_q == lim) begin
      div_n  = '0;
      sclk_n = ~sclk_q;
      tog    = 1'b1;
    end else begin
      div_n  = div_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q  <= '0;
      sclk_q <= 1'b0;
    end else begin
      div_q  <= div_n;
      sclk_q <= sclk_n;
    end
  end

  assign sclk    = sclk_q;
  assign stb.smp = tog & (sclk_q == idle_lvl);
  assign stb.drv = tog & (sclk_q != idle_lvl);
endmodule

// File: rtl/ssh_sclk_sync.sv
module ssh_sclk_sync
  import ssh_pkg::*;
#(
  parameter int STAGES = SYNC_STAGES
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     en,
  input  logic     idle_lvl,
  input  logic     sclk_async,
  output ssh_stb_t stb
);
  logic [STAGES-1:0] chain_q;
  logic              last_q;
  logic              rise, fall;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_sync
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[g] <= 1'b0;
          else        chain_q[g] <= sclk_async;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[g] <= 1'b0;
          else        chain_q[g] <= chain_q[g-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) last_q <= 1'b0;
    else        last_q <= chain_q[STAGES-1];
  end

  assign rise    = chain_q[STAGES-1] & ~last_q;
  assign fall    = ~chain_q[STAGES-1] & last_q;
  assign stb.smp = en & (idle_lvl ? fall : rise);
  assign stb.drv = en & (idle_lvl ? rise : fall);
endmodule

// File: rtl/ssh_shift_engine.sv
module ssh_shift_engine
  import ssh_pkg::*;
#(
  parameter int W = WORD_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         lsb_first,
  input  logic         load,
  input  logic [W-1:0] load_data,
  input  ssh_stb_t     stb,
  input  logic         sdi,
  output logic         busy,
  output logic         sdo,
  output logic [W-1:0] rx_data,
  output logic         done
);
  localparam int CNT_W = $clog2(W);

  logic [W-1:0]     sh_q, sh_n, rx_q, rx_n;
  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic             busy_q, busy_n, bit_q, bit_n, done_q, done_n;

  always_comb begin
    sh_n   = sh_q;
    rx_n   = rx_q;
    cnt_n  = cnt_q;
    busy_n = busy_q;
    bit_n  = bit_q;
    done_n = 1'b0;
    if (!busy_q) begin
      if (load) begin
        busy_n = 1'b1;
        sh_n   = load_data;
        cnt_n  = '0;
      end
    end else begin
      if (stb.smp) bit_n = sdi;
      if (stb.drv) begin
        sh_n  = lsb_first ? {bit_q, sh_q[W-1:1]} : {sh_q[W-2:0], bit_q};
        cnt_n = cnt_q + 1'b1;
        if (cnt_q == CNT_W'(W - 1)) begin
          busy_n = 1'b0;
          rx_n   = sh_n;
          done_n = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '0;
      rx_q   <= '0;
      cnt_q  <= '0;
      busy_q <= 1'b0;
      bit_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      sh_q   <= sh_n;
      rx_q   <= rx_n;
      cnt_q  <= cnt_n;
      busy_q <= busy_n;
      bit_q  <= bit_n;
      done_q <= done_n;
    end
  end

  assign busy    = busy_q;
  assign sdo     = lsb_first ? sh_q[0] : sh_q[W-1];
  assign rx_data = rx_q;
  assign done    = done_q;
endmodule

// File: rtl/tri_wire_shifter.sv
module tri_wire_shifter
  import ssh_pkg::*;
#(
  parameter int W      = WORD_W,
  parameter int STAGES = DIV_STAGES,
  parameter int SYNC_N = SYNC_STAGES
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      cfg_master,
  input  logic                      cfg_lsb_first,
  input  logic                      cfg_sample_fall,
  input  logic [$clog2(STAGES)-1:0] cfg_div_sel,
  input  logic                      tx_wr,
  input  logic [W-1:0]              tx_data,
  output logic [W-1:0]              rx_data,
  output logic                      ready,
  output logic                      done_irq,
  output logic                      sclk_out,
  input  logic                      sclk_in,
  input  logic                      sdi,
  output logic                      sdo
);
  logic [1:0] rst_sync_q;
  logic       rst_i;
  logic       busy;
  ssh_stb_t   m_stb, s_stb, stb;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_i = rst_sync_q[1];

  ssh_mclk_gen #(.STAGES(STAGES)) u_mclk (
    .clk      (clk),
    .rst_n    (rst_i),
    .en       (busy & cfg_master),
    .idle_lvl (cfg_sample_fall),
    .div_sel  (cfg_div_sel),
    .sclk     (sclk_out),
    .stb      (m_stb)
  );

  ssh_sclk_sync #(.STAGES(SYNC_N)) u_sync (
    .clk        (clk),
    .rst_n      (rst_i),
    .en         (~cfg_master),
    .idle_lvl   (cfg_sample_fall),
    .sclk_async (sclk_in),
    .stb        (s_stb)
  );

  assign stb = cfg_master ? m_stb : s_stb;

  ssh_shift_engine #(.W(W)) u_eng (
    .clk       (clk),
    .rst_n     (rst_i),
    .lsb_first (cfg_lsb_first),
    .load      (tx_wr),
    .load_data (tx_data),
    .stb       (stb),
    .sdi       (sdi),
    .busy      (busy),
    .sdo       (sdo),
    .rx_data   (rx_data),
    .done      (done_irq)
  );

  assign ready = busy;
endmodule

// File: rtl/ssh_chk.sv
module ssh_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         cfg_sample_fall,
  input logic         ready,
  input logic         done_irq,
  input logic         sclk_out,
  input logic [W-1:0] rx_data
);
  // R7
  irq_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_irq |=> !done_irq);

  // R7
  irq_at_ready_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_irq |-> (!ready && $past(ready)));

  // R7
  rx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !done_irq |-> $stable(rx_data));

  // R2
  start_at_rest_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(ready) && $stable(cfg_sample_fall)) |-> (sclk_out == cfg_sample_fall && !done_irq));

  // R1
  idle_rest_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ready && $past(!ready) && $stable(cfg_sample_fall) && $past(rst_n, 4))
      |-> (sclk_out == cfg_sample_fall));
endmodule

bind tri_wire_shifter ssh_chk #(.W(W)) u_ssh_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .cfg_sample_fall (cfg_sample_fall),
  .ready           (ready),
  .done_irq        (done_irq),
  .sclk_out        (sclk_out),
  .rx_data         (rx_data)
);

// File: tb/tri_wire_shifter_bench.sv
module tri_wire_shifter_bench;
  localparam int CLK_PERIOD = 10;
  localparam int SLV_HALF   = 6;

  typedef struct {
    logic [7:0] rx;
    logic [7:0] seq;
    int         cyc;
    logic       master;
  } exp_t;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_master = 1'b1, cfg_lsb_first = 1'b0, cfg_sample_fall = 1'b0;
  logic [1:0] cfg_div_sel = 2'd0;
  logic       tx_wr = 1'b0;
  logic [7:0] tx_data = 8'h00;
  logic       sclk_in = 1'b0, sdi_drv = 1'b0;
  logic [7:0] rx_data;
  logic       ready, done_irq, sclk_out, sdo, sdi;

  exp_t q[$];
  int   checks = 0, fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign sdi = cfg_master ? sdo : sdi_drv;

  tri_wire_shifter u_tri_wire_shifter (
    .clk(clk), .rst_n(rst_n), .cfg_master(cfg_master), .cfg_lsb_first(cfg_lsb_first),
    .cfg_sample_fall(cfg_sample_fall), .cfg_div_sel(cfg_div_sel), .tx_wr(tx_wr),
    .tx_data(tx_data), .rx_data(rx_data), .ready(ready), .done_irq(done_irq),
    .sclk_out(sclk_out), .sclk_in(sclk_in), .sdi(sdi), .sdo(sdo)
  );

  task automatic chk(input string req, input logic ok, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] rev8(input logic [7:0] d);
    for (int i = 0; i < 8; i++) rev8[i] = d[7-i];
  endfunction

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_cfg(input logic m, input logic lsb, input logic fall, input logic [1:0] sel);
    cfg_master = m; cfg_lsb_first = lsb; cfg_sample_fall = fall; cfg_div_sel = sel;
    sclk_in = fall;
    wait_cyc(6);
  endtask

  task automatic write_byte(input logic [7:0] d);
    tx_data = d; tx_wr = 1'b1;
    @(negedge clk);
    tx_wr = 1'b0;
    #1;
    // R2
    chk("R2 ready after write", ready === 1'b1, ready, 1);
    if (cfg_master)
      chk("R2 clock at rest on start", sclk_out === cfg_sample_fall, sclk_out, cfg_sample_fall);
  endtask

  task automatic master_xfer(input logic [7:0] d, input bit mid_write);
    exp_t e;
    e.rx = d; e.seq = cfg_lsb_first ? rev8(d) : d;
    e.cyc = 16 << cfg_div_sel; e.master = 1'b1;
    q.push_back(e);
    write_byte(d);
    if (mid_write) begin
      // R10: second write during the transfer
      wait_cyc(5);
      tx_data = ~d; tx_wr = 1'b1;
      @(negedge clk);
      tx_wr = 1'b0;
    end
    while (ready) @(negedge clk);
    wait_cyc(3);
  endtask

  task automatic slave_xfer(input logic [7:0] d, input logic [7:0] incoming);
    exp_t e;
    e.rx = incoming; e.seq = cfg_lsb_first ? rev8(d) : d;
    e.cyc = -1; e.master = 1'b0;
    q.push_back(e);
    write_byte(d);
    for (int i = 0; i < 8; i++) begin
      sdi_drv = cfg_lsb_first ? incoming[i] : incoming[7-i];
      wait_cyc(SLV_HALF);
      sclk_in = ~cfg_sample_fall;
      wait_cyc(SLV_HALF);
      sclk_in = cfg_sample_fall;
    end
    while (ready) @(negedge clk);
    wait_cyc(3);
  endtask

  // monitor / scoreboard
  initial begin
    logic       prev_line = 1'b0, line, prev_done = 1'b0, slave_bad = 1'b0;
    logic [7:0] seq = 8'h00;
    int         nsmp = 0, busy_cyc = 0;
    exp_t       e;
    forever begin
      @(negedge clk);
      #1;
      if (rst_n) begin
        line = cfg_master ? sclk_out : sclk_in;
        if (ready) begin
          busy_cyc++;
          if (line != prev_line && line != cfg_sample_fall) begin
            seq = {seq[6:0], sdo};
            nsmp++;
          end
          if (!cfg_master && sclk_out != cfg_sample_fall) slave_bad = 1'b1;
        end
        // R7
        if (prev_done && done_irq) chk("R7 irq longer than one cycle", 1'b0, 1, 0);
        if (done_irq) begin
          chk("R7 ready low with irq", ready === 1'b0, ready, 0);
          if (q.size() == 0) begin
            chk("R7 unexpected irq", 1'b0, 1, 0);
          end else begin
            e = q.pop_front();
            // R5
            chk("R5 received byte", rx_data === e.rx, rx_data, e.rx);
            // R3 / R4
            chk(cfg_lsb_first ? "R4 lsb-first sdo order" : "R3 msb-first sdo order",
                seq === e.seq, seq, e.seq);
            chk("R8 eight sampling edges", nsmp == 8, nsmp, 8);
            if (e.master) begin
              // R6
              chk("R6 transfer length", busy_cyc == e.cyc, busy_cyc, e.cyc);
            end else begin
              // R11
              chk("R11 sclk_out at rest in slave", !slave_bad, slave_bad, 0);
            end
          end
          nsmp = 0; busy_cyc = 0; seq = 8'h00; slave_bad = 1'b0;
        end
        prev_line = line;
        prev_done = done_irq;
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    wait_cyc(3);
    rst_n = 1'b1;
    wait_cyc(5);
    #1;
    // R1
    chk("R1 ready reset", ready === 1'b0, ready, 0);
    chk("R1 irq reset", done_irq === 1'b0, done_irq, 0);
    chk("R1 rx reset", rx_data === 8'h00, rx_data, 0);
    chk("R1 clock rest", sclk_out === 1'b0, sclk_out, 0);

    set_cfg(1'b1, 1'b0, 1'b0, 2'd0);
    master_xfer(8'hA5, 1'b0);
    set_cfg(1'b1, 1'b1, 1'b0, 2'd1);
    master_xfer(8'h3C, 1'b0);
    set_cfg(1'b1, 1'b0, 1'b1, 2'd2);
    #1;
    chk("R1 clock rest high", sclk_out === 1'b1, sclk_out, 1);
    master_xfer(8'h96, 1'b0);
    set_cfg(1'b1, 1'b1, 1'b1, 2'd3);
    master_xfer(8'h01, 1'b0);
    set_cfg(1'b1, 1'b0, 1'b0, 2'd1);
    master_xfer(8'hC3, 1'b1);

    set_cfg(1'b0, 1'b0, 1'b0, 2'd0);
    slave_xfer(8'h6D, 8'hB2);

    set_cfg(1'b0, 1'b1, 1'b1, 2'd0);
    // R9: stray edges while not armed
    for (int i = 0; i < 3; i++) begin
      sclk_in = ~cfg_sample_fall; wait_cyc(SLV_HALF);
      sclk_in = cfg_sample_fall;  wait_cyc(SLV_HALF);
    end
    #1;
    chk("R9 not armed stays idle", ready === 1'b0 && done_irq === 1'b0, ready, 0);
    chk("R9 rx untouched", rx_data === 8'hB2, rx_data, 8'hB2);
    slave_xfer(8'h8E, 8'h7E);

    wait_cyc(5);
    chk("R7 all transfers completed", q.size() == 0, q.size(), 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule